// File: doc/BRIEF.md
# Single-precision floating-point adder/subtractor

This block adds or subtracts two 32-bit IEEE-754 single-precision numbers, or negates the first one. An op code chooses the operation. Subtract and reverse-subtract invert a sign bit on the way in, so one datapath serves all three arithmetic operations. That path orders the operands by magnitude and aligns the smaller one while keeping guard, round and sticky bits. It then adds or subtracts the significands, normalizes the sum and rounds it to nearest with ties to even.

Operands that are infinity or NaN are caught by a separate classifier and take a shortcut result. Zeros and subnormals go through the arithmetic path, which treats a zero exponent field as exponent one with no hidden bit. The result is registered. It appears one clock after a cycle with `in_valid` high, and `out_valid` marks it.

Top module: `fp_addsub`

## Requirements
- R1: `op` selects the operation: 2'b00 gives a+b, 2'b01 gives a-b, 2'b10 gives b-a, 2'b11 gives a with bit 31 inverted and every other bit unchanged (this holds for NaN too), and b is ignored.
- R2: `result` and `out_valid` are registered. `out_valid` equals the previous cycle's `in_valid`. `result` loads only when `in_valid` is high and holds otherwise. A synchronous active-high `rst` clears both to zero.
- R3: Finite results are rounded to nearest. A result lying exactly halfway between two representable values takes the one whose least significant fraction bit is 0.
- R4: An exact cancellation of two nonzero values gives +0 (0x00000000). (+0)+(-0) gives +0, and (-0)+(-0) gives -0.
- R5: A nonzero x combined with a zero of either sign returns x bit for bit.
- R6: An input with exponent field 0 is read as a subnormal: no hidden bit, exponent one. Results too small for a normal exponent are returned as subnormals with their sign.
- R7: A finite result whose rounded exponent reaches 255 returns sign | 0x7F800000. Two finite operands never produce a NaN.
- R8: When the biased exponents differ by 26 or more, the operand of larger magnitude is returned unchanged, with its effective sign.
- R9: An infinity combined with a finite value returns that infinity with its effective sign. Two infinities of the same effective sign return that infinity.
- R10: If either operand is a NaN, or the operands are infinities of opposite effective sign, the result is a NaN with exponent 0xFF and bit 22 (the quiet bit) set.
- R11: Adding a value to itself doubles it exactly. This includes a subnormal becoming the smallest normal, and 0x7F000000 overflowing to infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 2 | Operation select: add, subtract, reverse-subtract, negate |
| a | input | 32 | First operand, single-precision |
| b | input | 32 | Second operand, single-precision |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Registered single-precision result |

## Verification
The hardest cases to reach from the ports are those where rounding interacts with a change of exponent. Examples are a subtraction across a power of two, where the sticky bit ends up in the round position after the one-bit left shift, and an addition whose round-up carries out of the significand into the overflow exponent. The stimulus builds these from hand-picked exponent gaps of 24, 25 and 26 around 1.0, 2^26 and the largest finite value. Subnormal pairs are placed at the normal/subnormal boundary from both sides. NaN results are checked by class and quiet bit, not by payload.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_RSUB = 2'b10,
    OP_NEG  = 2'b11
  } fpa_op_e;
endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] x,
  input  logic [EW+FW:0] y,
  output logic [FW+4:0]  sum,
  output logic [EW+1:0]  e_big,
  output logic           s_big,
  output logic           z_sign
);
  localparam int MW = FW + 1;
  localparam int XW = MW + 3;

  logic            swap, eff_sub, st;
  logic [EW+FW:0]  big, sml;
  logic [EW-1:0]   eb, es, d;
  logic [MW-1:0]   mb, ms;
  logic [XW-1:0]   t, sh, mask, addend;

  always_comb begin
    swap  = y[EW+FW-1:0] > x[EW+FW-1:0];
    big   = swap ? y : x;
    sml   = swap ? x : y;
    eb    = (big[EW+FW-1:FW] == '0) ? EW'(1) : big[EW+FW-1:FW];
    es    = (sml[EW+FW-1:FW] == '0) ? EW'(1) : sml[EW+FW-1:FW];
    mb    = {big[EW+FW-1:FW] != '0, big[FW-1:0]};
    ms    = {sml[EW+FW-1:FW] != '0, sml[FW-1:0]};
    d     = eb - es;
    t     = {ms, 3'b000};
    mask  = '0;
    if (d >= EW'(XW)) begin
      sh = '0;
      st = |t;
    end else begin
      sh   = t >> d;
      mask = ~({XW{1'b1}} << d);
      st   = |(t & mask);
    end
    addend  = sh | {{(XW-1){1'b0}}, st};
    eff_sub = big[EW+FW] ^ sml[EW+FW];
    if (eff_sub) sum = {1'b0, mb, 3'b000} - {1'b0, addend};
    else         sum = {1'b0, mb, 3'b000} + {1'b0, addend};
    e_big  = {2'b00, eb};
    s_big  = big[EW+FW];
    z_sign = eff_sub ? 1'b0 : big[EW+FW];
  end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [FW+4:0]  sum,
  input  logic [EW+1:0]  e_in,
  input  logic           s_big,
  input  logic           z_sign,
  output logic [EW+FW:0] word
);
  localparam int MW   = FW + 1;
  localparam int XW   = MW + 3;
  localparam int EXW  = EW + 2;
  localparam int LZW  = $clog2(XW + 1);
  localparam int EMAX = (1 << EW) - 1;

  logic [LZW-1:0] lz;
  logic [EXW-1:0] sh, lim, e1, e2;
  logic [XW-1:0]  norm;
  logic [MW-1:0]  keep, mant;
  logic [MW:0]    rnd;
  logic           up;

  always_comb begin
    lz = LZW'(XW);
    for (int i = 0; i < XW; i++) begin
      if (sum[i]) lz = LZW'(XW - 1 - i);
    end
  end

  always_comb begin
    lim = e_in - EXW'(1);
    sh  = '0;
    if (sum[XW]) begin
      norm = {sum[XW:2], sum[1] | sum[0]};
      e1   = e_in + EXW'(1);
    end else begin
      sh   = (EXW'(lz) > lim) ? lim : EXW'(lz);
      norm = sum[XW-1:0] << sh;
      e1   = e_in - sh;
    end
    keep = norm[XW-1:3];
    up   = norm[2] & (norm[1] | norm[0] | keep[0]);
    rnd  = {1'b0, keep} + {{MW{1'b0}}, up};
    if (rnd[MW]) begin
      e2   = e1 + EXW'(1);
      mant = rnd[MW:1];
    end else begin
      e2   = e1;
      mant = rnd[MW-1:0];
    end
    if (sum == '0)
      word = {z_sign, {(EW+FW){1'b0}}};
    else if (mant[MW-1] && (e2 >= EXW'(EMAX)))
      word = {s_big, {EW{1'b1}}, {FW{1'b0}}};
    else
      word = {s_big, (mant[MW-1] ? e2[EW-1:0] : {EW{1'b0}}), mant[FW-1:0]};
  end
endmodule

// File: rtl/fpa_special.sv
module fpa_special #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] x,
  input  logic [EW+FW:0] y,
  output logic           hit,
  output logic [EW+FW:0] word
);
  localparam logic [EW+FW:0] QBIT = {{(EW+1){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  logic x_top, y_top, x_nan, y_nan;

  always_comb begin
    x_top = &x[EW+FW-1:FW];
    y_top = &y[EW+FW-1:FW];
    x_nan = x_top && (x[FW-1:0] != '0);
    y_nan = y_top && (y[FW-1:0] != '0);
    hit   = x_top | y_top;
    if (x_nan)
      word = x | QBIT;
    else if (y_nan)
      word = y | QBIT;
    else if (x_top && y_top && (x[EW+FW] != y[EW+FW]))
      word = {x[EW+FW], {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
    else if (x_top)
      word = x;
    else
      word = y;
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [EW+FW:0]   a,
  input  logic [EW+FW:0]   b,
  output logic             out_valid,
  output logic [EW+FW:0]   result
);
  import fpa_pkg::*;
  localparam int DW = EW + FW + 1;

  fpa_op_e        opc;
  logic [DW-1:0]  x, y, neg_word, sp_word, ar_word, nxt;
  logic [FW+4:0]  sum;
  logic [EW+1:0]  e_big;
  logic           s_big, z_sign, sp_hit;

  always_comb begin
    opc = fpa_op_e'(op);
    x   = a;
    y   = b;
    case (opc)
      OP_SUB:  y[DW-1] = ~b[DW-1];
      OP_RSUB: x[DW-1] = ~a[DW-1];
      default: ;
    endcase
    neg_word = {~a[DW-1], a[DW-2:0]};
  end

  fpa_align #(.EW(EW), .FW(FW)) u_align (
    .x(x), .y(y), .sum(sum), .e_big(e_big), .s_big(s_big), .z_sign(z_sign)
  );

  fpa_norm_round #(.EW(EW), .FW(FW)) u_norm (
    .sum(sum), .e_in(e_big), .s_big(s_big), .z_sign(z_sign), .word(ar_word)
  );

  fpa_special #(.EW(EW), .FW(FW)) u_spec (
    .x(x), .y(y), .hit(sp_hit), .word(sp_word)
  );

  always_comb begin
    if (opc == OP_NEG) nxt = neg_word;
    else if (sp_hit)   nxt = sp_word;
    else               nxt = ar_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/fpa_check.sv
module fpa_check #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [1:0]     op,
  input logic [EW+FW:0] a,
  input logic [EW+FW:0] b,
  input logic           out_valid,
  input logic [EW+FW:0] result
);
  localparam int DW = EW + FW + 1;

  logic a_top, b_top, a_nan, r_top, r_fz;
  assign a_top = &a[DW-2:FW];
  assign b_top = &b[DW-2:FW];
  assign a_nan = a_top && (a[FW-1:0] != '0);
  assign r_top = &result[DW-2:FW];
  assign r_fz  = (result[FW-1:0] == '0);

  AST_VALID_ON: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result))); // R2
  AST_NEG_BIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=>
      (result == {~$past(a[DW-1]), $past(a[DW-2:0])})); // R1
  AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && a == b && !a_top) |=> (result == '0)); // R4
  AST_ZERO_IDENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && b[DW-2:0] == '0 && a[DW-2:0] != '0 && !a_nan)
      |=> (result == $past(a))); // R5
  AST_QUIET_NAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 2'b11) |=> (!r_top || r_fz || result[FW-1])); // R10
  AST_FINITE_NO_NAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 2'b11 && !a_top && !b_top) |=> (!r_top || r_fz)); // R7
endmodule

bind fp_addsub fpa_check #(.EW(EW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
  .out_valid(out_valid), .result(result)
);

// File: tb/sim_fp_addsub.sv
`timescale 1ns/1ps
module sim_fp_addsub;
  logic        clk = 1'b0;
  logic        rst, in_valid;
  logic [1:0]  op;
  logic [31:0] a, b;
  logic        out_valid;
  logic [31:0] result;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_addsub u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .out_valid(out_valid), .result(result)
  );

  // {requirement, op, a, b, expected}
  localparam int NV = 36;
  localparam logic [101:0] VEC [NV] = '{
    {4'd1,  2'd0, 32'h3F800000, 32'h40000000, 32'h40400000}, // R1 add
    {4'd1,  2'd1, 32'h3F800000, 32'h40000000, 32'hBF800000}, // R1 sub
    {4'd1,  2'd2, 32'h3F800000, 32'h40000000, 32'h3F800000}, // R1 rsub
    {4'd1,  2'd3, 32'h3F800000, 32'h40400000, 32'hBF800000}, // R1 neg
    {4'd1,  2'd3, 32'h7FA00000, 32'h3F800000, 32'hFFA00000}, // R1 neg NaN
    {4'd1,  2'd3, 32'h80000000, 32'h7F800000, 32'h00000000}, // R1 b ignored
    {4'd3,  2'd0, 32'h3F800000, 32'h33800000, 32'h3F800000}, // R3 tie down
    {4'd3,  2'd0, 32'h3F800001, 32'h33800000, 32'h3F800002}, // R3 tie up
    {4'd3,  2'd0, 32'h3F800000, 32'h33C00000, 32'h3F800001}, // R3 above half
    {4'd3,  2'd0, 32'h3F800000, 32'hB3400000, 32'h3F7FFFFF}, // R3 gap 25
    {4'd4,  2'd1, 32'h3FC00000, 32'h3FC00000, 32'h00000000}, // R4
    {4'd4,  2'd0, 32'h00000000, 32'h80000000, 32'h00000000}, // R4
    {4'd4,  2'd0, 32'h80000000, 32'h80000000, 32'h80000000}, // R4
    {4'd4,  2'd0, 32'hBFC00000, 32'h3FC00000, 32'h00000000}, // R4
    {4'd5,  2'd0, 32'h40490FDB, 32'h80000000, 32'h40490FDB}, // R5
    {4'd5,  2'd0, 32'h00000000, 32'hC0000000, 32'hC0000000}, // R5
    {4'd5,  2'd0, 32'h00000001, 32'h00000000, 32'h00000001}, // R5
    {4'd6,  2'd0, 32'h00000001, 32'h00000001, 32'h00000002}, // R6
    {4'd6,  2'd0, 32'h007FFFFF, 32'h00000001, 32'h00800000}, // R6
    {4'd6,  2'd1, 32'h00800000, 32'h00000001, 32'h007FFFFF}, // R6
    {4'd6,  2'd0, 32'h80800000, 32'h00000001, 32'h807FFFFF}, // R6
    {4'd6,  2'd1, 32'h00C00000, 32'h00800000, 32'h00400000}, // R6
    {4'd7,  2'd0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000}, // R7
    {4'd7,  2'd0, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000}, // R7
    {4'd7,  2'd0, 32'h7F7FFFFF, 32'h73000000, 32'h7F800000}, // R7 round carry
    {4'd8,  2'd0, 32'h4C800000, 32'h3F800000, 32'h4C800000}, // R8
    {4'd8,  2'd1, 32'h4C800000, 32'h3F800000, 32'h4C800000}, // R8
    {4'd8,  2'd0, 32'h7F000000, 32'h00000001, 32'h7F000000}, // R8
    {4'd8,  2'd0, 32'hC0000000, 32'h00000003, 32'hC0000000}, // R8
    {4'd9,  2'd0, 32'h7F800000, 32'h3F800000, 32'h7F800000}, // R9
    {4'd9,  2'd1, 32'h3F800000, 32'h7F800000, 32'hFF800000}, // R9
    {4'd9,  2'd0, 32'h7F800000, 32'h7F800000, 32'h7F800000}, // R9
    {4'd9,  2'd2, 32'h7F800000, 32'h00000000, 32'hFF800000}, // R9
    {4'd11, 2'd0, 32'h3F800000, 32'h3F800000, 32'h40000000}, // R11
    {4'd11, 2'd0, 32'h7F000000, 32'h7F000000, 32'h7F800000}, // R11
    {4'd11, 2'd0, 32'h00400000, 32'h00400000, 32'h00800000}  // R11
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_nan(input string tag, input logic [31:0] got);
    total++;
    if (!((&got[30:23]) && got[22])) begin
      bad++;
      $display("FAIL %s got=%h exp=quiet NaN", tag, got);
    end
  endtask

  task automatic drive(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; op = 2'd0; a = 32'h3F800000; b = 32'h3F800000;
    repeat (3) @(negedge clk);
    chk("R2 reset result", result, 32'h0);
    chk("R2 reset valid", {31'b0, out_valid}, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][97:96], VEC[i][95:64], VEC[i][63:32]);
      chk($sformatf("R%0d vec %0d", VEC[i][101:98], i), result, VEC[i][31:0]);
      if (i == 0) chk("R2 valid after input", {31'b0, out_valid}, 32'h1);
    end

    drive(2'd0, 32'h7F800000, 32'hFF800000); chk_nan("R10 inf minus inf", result);
    drive(2'd0, 32'h7FC00000, 32'h3F800000); chk_nan("R10 quiet NaN in", result);
    drive(2'd0, 32'h3F800000, 32'h7F800001); chk_nan("R10 signalling NaN b", result);
    drive(2'd1, 32'h7F800001, 32'h00000000); chk_nan("R10 signalling NaN a", result);
    drive(2'd2, 32'hFF800000, 32'hFF800000); chk_nan("R10 rsub infinities", result);

    drive(2'd0, 32'h40000000, 32'h40000000);
    chk("R11 before hold", result, 32'h40800000);
    op = 2'd1; a = 32'h12345678; b = 32'h3F800000; in_valid = 1'b0;
    @(negedge clk);
    chk("R2 valid low", {31'b0, out_valid}, 32'h0);
    chk("R2 result hold", result, 32'h40800000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule